// File: doc/BRIEF.md
# Time-of-Day Clock with Atomic Offset

The block keeps a nanosecond-and-seconds time base for IEEE 1588 timestamping. A free-running counter advances every clock cycle by a programmable unsigned fixed-point step (20 fractional nanosecond bits). The fraction carries over from cycle to cycle, so software can trim the rate in very fine steps. A separately held offset is added to the counter to form the reported time. Both values use the same rule: nanoseconds wrap at one second and carry into a 48-bit seconds field.

Software works through eight 32-bit word registers. The offset is staged in two seconds words and becomes active, together with the nanoseconds word, at the moment the nanoseconds word is written. A read of the reported nanoseconds word freezes the matching seconds value, so a seconds read that follows returns a coherent pair. A pending interrupt flag is set a fixed number of times per reported second. Writing a 1 to its bit clears it.

Top module: `tod_rtc`

## Requirements
- R1: After reset the counter and the active and staged offset are zero, the step register reads 0x0080_0000, the pending flag and `irq_o` are 0, and `rdata_o` is 0.
- R2: Each cycle the counter adds the step register value, taken as nanoseconds with 20 fractional bits. The fractional part accumulates, so a step of 0x0088_0000 (8.5 ns) advances 17 ns every two cycles.
- R3: Counter nanoseconds wrap at `NS_PER_SEC` and carry one into the 48-bit seconds field. Seconds carry from bit 31 into bit 32.
- R4: Reported time equals counter plus active offset. The nanosecond sum wraps at `NS_PER_SEC` and carries into the seconds sum.
- R5: Writes to word 3 (offset seconds bits 47:32, taken from data bits 15:0) and word 4 (offset seconds bits 31:0) only stage a value. Neither the offset readback nor the reported time changes until word 5 (offset nanoseconds) is written. After that write, all three parts take effect together at the same clock edge.
- R6: A read strobe returns the addressed word on `rdata_o` one cycle later, and `rdata_o` holds it after that. Word 0 returns the reported nanoseconds and captures the reported seconds at the same edge. Word 1 returns bits 31:0 of that capture and word 2 returns bits 47:32.
- R7: Words 3, 4 and 5 read back the active offset. Word 6 holds the step, is readable and writable, and a new step applies from the edge after the write.
- R8: The pending flag is set when the reported nanoseconds value crosses a multiple of `NS_PER_SEC / TICKS_PER_SEC`, including the wrap to zero. A jump caused by an offset load does not set it.
- R9: Word 7 bit 0 reads the pending flag, and `irq_o` equals it. Writing 1 to bit 0 clears the flag and writing 0 leaves it alone. A crossing at the same edge as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe for the word at `addr_i` |
| wr_i | input | 1 | Write strobe for the word at `addr_i` |
| addr_i | input | 3 | Word select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_i` |
| irq_o | output | 1 | Pending tick interrupt |

## Verification
The bench builds the block with `NS_PER_SEC` = 12800 and `TICKS_PER_SEC` = 128. This makes a second about 1600 cycles long at the 8 ns default step and makes a tick every 100 ns. As a result, both the seconds carry and the tick crossings appear within a short run. The bench also writes an offset of 0xAB_FFFF_FFFF seconds, which drives the reported seconds across the 32-bit word boundary. A step of zero freezes the time base, so the bench can show that an offset jump sets no flag. A step of 100 ns puts a crossing on every edge, so the bench can test a clear that coincides with a tick.

// File: rtl/tod_rtc_pkg.sv
package tod_rtc_pkg;
  localparam int unsigned REG_DW  = 32;
  localparam int unsigned IRQ_BIT = 0;

  typedef enum logic [2:0] {
    REG_TIME_NS     = 3'd0,
    REG_TIME_SEC_LO = 3'd1,
    REG_TIME_SEC_HI = 3'd2,
    REG_OFS_SEC_HI  = 3'd3,
    REG_OFS_SEC_LO  = 3'd4,
    REG_OFS_NS      = 3'd5,
    REG_STEP        = 3'd6,
    REG_IRQ         = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int unsigned NS_PER_SEC = 1_000_000_000,
  parameter int unsigned NS_W       = 30,
  parameter int unsigned FRAC_W     = 20,
  parameter int unsigned SEC_W      = 48,
  parameter int unsigned STEP_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STEP_W-1:0] step_i,
  output logic [NS_W-1:0]   ns_o,
  output logic [SEC_W-1:0]  sec_o
);
  localparam int unsigned ACC_W = NS_W + FRAC_W;

  logic [ACC_W-1:0] acc_q;
  logic [SEC_W-1:0] sec_q;
  logic [ACC_W:0]   sum;
  logic [NS_W:0]    ns_raw;
  logic [NS_W-1:0]  ns_next;
  logic             wrap;

  always_comb begin
    sum     = {1'b0, acc_q} + (ACC_W+1)'(step_i);
    ns_raw  = sum[ACC_W:FRAC_W];
    wrap    = ns_raw >= (NS_W+1)'(NS_PER_SEC);
    ns_next = wrap ? NS_W'(ns_raw - (NS_W+1)'(NS_PER_SEC)) : NS_W'(ns_raw);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      sec_q <= '0;
    end else begin
      acc_q <= {ns_next, sum[FRAC_W-1:0]};
      sec_q <= sec_q + SEC_W'(wrap);
    end
  end

  assign ns_o  = acc_q[ACC_W-1:FRAC_W];
  assign sec_o = sec_q;

  // R3: nanoseconds stay below one second
  a_r3_ns_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ns_o < NS_W'(NS_PER_SEC));

  // R3: seconds advance by at most one per cycle
  a_r3_sec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_o == $past(sec_o)) || (sec_o == $past(sec_o) + SEC_W'(1)));
endmodule

// File: rtl/tod_offset.sv
module tod_offset #(
  parameter int unsigned NS_PER_SEC = 1_000_000_000,
  parameter int unsigned NS_W       = 30,
  parameter int unsigned SEC_W      = 48
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hi_we_i,
  input  logic                lo_we_i,
  input  logic                commit_i,
  input  logic [SEC_W-33:0]   hi_d_i,
  input  logic [31:0]         lo_d_i,
  input  logic [NS_W-1:0]     ns_d_i,
  input  logic [NS_W-1:0]     cnt_ns_i,
  input  logic [SEC_W-1:0]    cnt_sec_i,
  output logic [NS_W-1:0]     ofs_ns_o,
  output logic [SEC_W-1:0]    ofs_sec_o,
  output logic [NS_W-1:0]     rep_ns_o,
  output logic [SEC_W-1:0]    rep_sec_o
);
  localparam int unsigned HI_W = SEC_W - 32;

  logic [HI_W-1:0]  stg_hi_q;
  logic [31:0]      stg_lo_q;
  logic [NS_W-1:0]  ofs_ns_q;
  logic [SEC_W-1:0] ofs_sec_q;
  logic [NS_W:0]    ns_sum;
  logic             carry;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_hi_q  <= '0;
      stg_lo_q  <= '0;
      ofs_ns_q  <= '0;
      ofs_sec_q <= '0;
    end else begin
      if (hi_we_i) stg_hi_q <= hi_d_i;
      if (lo_we_i) stg_lo_q <= lo_d_i;
      if (commit_i) begin
        ofs_ns_q  <= ns_d_i;
        ofs_sec_q <= {stg_hi_q, stg_lo_q};
      end
    end
  end

  always_comb begin
    ns_sum    = {1'b0, cnt_ns_i} + {1'b0, ofs_ns_q};
    carry     = ns_sum >= (NS_W+1)'(NS_PER_SEC);
    rep_ns_o  = carry ? NS_W'(ns_sum - (NS_W+1)'(NS_PER_SEC)) : NS_W'(ns_sum);
    rep_sec_o = cnt_sec_i + ofs_sec_q + SEC_W'(carry);
  end

  assign ofs_ns_o  = ofs_ns_q;
  assign ofs_sec_o = ofs_sec_q;

  // R5: staged writes leave the active offset untouched
  a_r5_offset_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(ofs_ns_o) && $stable(ofs_sec_o)));

  // R4: reported nanoseconds stay in range when the offset is in range
  a_r4_rep_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ofs_ns_o < NS_W'(NS_PER_SEC)) |-> (rep_ns_o < NS_W'(NS_PER_SEC)));
endmodule

// File: rtl/tod_tick.sv
module tod_tick #(
  parameter int unsigned NS_PER_SEC    = 1_000_000_000,
  parameter int unsigned TICKS_PER_SEC = 128,
  parameter int unsigned NS_W          = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NS_W-1:0] rep_ns_i,
  input  logic            jump_i,
  output logic            tick_o
);
  localparam int unsigned TICK_NS = NS_PER_SEC / TICKS_PER_SEC;
  localparam int unsigned IDX_W   = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;

  logic [IDX_W-1:0] idx_now, idx_q;
  logic             jump_q;

  assign idx_now = IDX_W'(rep_ns_i / NS_W'(TICK_NS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      jump_q <= 1'b0;
    end else begin
      idx_q  <= idx_now;
      jump_q <= jump_i;
    end
  end

  // interval index changed without an offset load in between
  assign tick_o = (idx_now != idx_q) && !jump_q;

  // R8: the wrap to zero of the reported time is a crossing
  a_r8_wrap_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rep_ns_i < $past(rep_ns_i)) && !$past(jump_i)) |-> tick_o);

  // R8: a frozen reported value produces no tick
  a_r8_still_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(rep_ns_i) |-> !tick_o);
endmodule

// File: rtl/tod_rtc.sv
module tod_rtc
  import tod_rtc_pkg::*;
#(
  parameter int unsigned NS_PER_SEC    = 1_000_000_000,
  parameter int unsigned TICKS_PER_SEC = 128,
  parameter int unsigned FRAC_W        = 20,
  parameter int unsigned SEC_W         = 48,
  parameter logic [31:0] STEP_RESET    = 32'h0080_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  localparam int unsigned NS_W = $clog2(NS_PER_SEC);
  localparam int unsigned HI_W = SEC_W - 32;

  reg_sel_e         sel;
  logic [31:0]      step_q;
  logic [NS_W-1:0]  cnt_ns, ofs_ns, rep_ns;
  logic [SEC_W-1:0] cnt_sec, ofs_sec, rep_sec, snap_q;
  logic [31:0]      rd_mux, rdata_q;
  logic             tick, irq_q, irq_clr, commit;

  assign sel     = reg_sel_e'(addr_i);
  assign commit  = wr_i && (sel == REG_OFS_NS);
  assign irq_clr = wr_i && (sel == REG_IRQ) && wdata_i[IRQ_BIT];

  tod_counter #(
    .NS_PER_SEC (NS_PER_SEC),
    .NS_W       (NS_W),
    .FRAC_W     (FRAC_W),
    .SEC_W      (SEC_W),
    .STEP_W     (32)
  ) u_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_q),
    .ns_o   (cnt_ns),
    .sec_o  (cnt_sec)
  );

  tod_offset #(
    .NS_PER_SEC (NS_PER_SEC),
    .NS_W       (NS_W),
    .SEC_W      (SEC_W)
  ) u_offset (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hi_we_i   (wr_i && (sel == REG_OFS_SEC_HI)),
    .lo_we_i   (wr_i && (sel == REG_OFS_SEC_LO)),
    .commit_i  (commit),
    .hi_d_i    (wdata_i[HI_W-1:0]),
    .lo_d_i    (wdata_i),
    .ns_d_i    (wdata_i[NS_W-1:0]),
    .cnt_ns_i  (cnt_ns),
    .cnt_sec_i (cnt_sec),
    .ofs_ns_o  (ofs_ns),
    .ofs_sec_o (ofs_sec),
    .rep_ns_o  (rep_ns),
    .rep_sec_o (rep_sec)
  );

  tod_tick #(
    .NS_PER_SEC    (NS_PER_SEC),
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .NS_W          (NS_W)
  ) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rep_ns_i (rep_ns),
    .jump_i   (commit),
    .tick_o   (tick)
  );

  always_comb begin
    unique case (sel)
      REG_TIME_NS:     rd_mux = 32'(rep_ns);
      REG_TIME_SEC_LO: rd_mux = snap_q[31:0];
      REG_TIME_SEC_HI: rd_mux = 32'(snap_q[SEC_W-1:32]);
      REG_OFS_SEC_HI:  rd_mux = 32'(ofs_sec[SEC_W-1:32]);
      REG_OFS_SEC_LO:  rd_mux = ofs_sec[31:0];
      REG_OFS_NS:      rd_mux = 32'(ofs_ns);
      REG_STEP:        rd_mux = step_q;
      REG_IRQ:         rd_mux = 32'(irq_q) << IRQ_BIT;
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= STEP_RESET;
      snap_q  <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_i && (sel == REG_STEP)) step_q <= wdata_i;
      if (rd_i) rdata_q <= rd_mux;
      if (rd_i && (sel == REG_TIME_NS)) snap_q <= rep_sec;
      irq_q <= tick | (irq_q & ~irq_clr);
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = irq_q;

  // R9: a crossing always leaves the flag set
  a_r9_tick_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> irq_o);

  // R9: a clear without a crossing drops the flag
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr && !tick) |=> !irq_o);

  // R6: read data only changes after a read strobe
  a_r6_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: tb/tb_tod_rtc.sv
module tb_tod_rtc;
  localparam int unsigned NPS   = 12800;
  localparam int unsigned TICKS = 128;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_IDLE = 2'd2;
  localparam int NV = 20;

  // {op, addr, data}
  localparam logic [36:0] VECS [NV] = '{
    {OP_RD,   3'd0, 32'd0},            // R2 R6 time ns
    {OP_RD,   3'd1, 32'd0},            // R6 snapshot seconds
    {OP_WR,   3'd6, 32'h0088_0000},    // R7 step 8.5 ns
    {OP_RD,   3'd6, 32'd0},            // R7
    {OP_IDLE, 3'd0, 32'd3},
    {OP_RD,   3'd0, 32'd0},            // R2 fraction
    {OP_WR,   3'd3, 32'h0000_00AB},    // R5 stage hi
    {OP_WR,   3'd4, 32'hFFFF_FFFF},    // R5 stage lo
    {OP_RD,   3'd3, 32'd0},            // R5 still old
    {OP_RD,   3'd4, 32'd0},            // R5 still old
    {OP_RD,   3'd0, 32'd0},            // R5 time unchanged by staging
    {OP_RD,   3'd1, 32'd0},
    {OP_WR,   3'd5, 32'd12000},        // R5 commit
    {OP_RD,   3'd3, 32'd0},            // R7 active hi
    {OP_RD,   3'd4, 32'd0},            // R7 active lo
    {OP_RD,   3'd5, 32'd0},            // R7 active ns
    {OP_RD,   3'd0, 32'd0},            // R4 carry from offset
    {OP_RD,   3'd1, 32'd0},            // R4
    {OP_IDLE, 3'd0, 32'd1700},         // R3 pass a second wrap
    {OP_RD,   3'd0, 32'd0}             // R3
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  tod_rtc #(.NS_PER_SEC(NPS), .TICKS_PER_SEC(TICKS)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #4 clk_i = ~clk_i;

  // reference model from the requirements
  longint m_acc, m_sec, m_step, m_ofs_ns, m_ofs_sec, m_hi, m_lo, m_snap;
  logic [31:0] exp_rd;
  localparam longint SEC_MASK = 64'h0000_FFFF_FFFF_FFFF;

  function automatic longint rep_ns();
    longint s = (m_acc >> 20) + m_ofs_ns;
    return (s >= NPS) ? s - NPS : s;
  endfunction

  function automatic longint rep_sec();
    longint s = (m_acc >> 20) + m_ofs_ns;
    return (m_sec + m_ofs_sec + ((s >= NPS) ? 1 : 0)) & SEC_MASK;
  endfunction

  function automatic logic [31:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return 32'(rep_ns());
      3'd1: return 32'(m_snap);
      3'd2: return 32'(m_snap >> 32);
      3'd3: return 32'(m_ofs_sec >> 32);
      3'd4: return 32'(m_ofs_sec);
      3'd5: return 32'(m_ofs_ns);
      3'd6: return 32'(m_step);
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin : model
    longint nxt;
    if (!rst_ni) begin
      m_acc <= 0; m_sec <= 0; m_step <= 64'h80_0000; m_ofs_ns <= 0;
      m_ofs_sec <= 0; m_hi <= 0; m_lo <= 0; m_snap <= 0; exp_rd <= '0;
    end else begin
      if (rd_i) exp_rd <= model_rd(addr_i);
      if (rd_i && addr_i == 3'd0) m_snap <= rep_sec();
      nxt = m_acc + m_step;
      if ((nxt >> 20) >= NPS) begin
        nxt = nxt - (longint'(NPS) << 20);
        m_sec <= (m_sec + 1) & SEC_MASK;
      end
      m_acc <= nxt;
      if (wr_i) begin
        case (addr_i)
          3'd3: m_hi <= longint'(wdata_i[15:0]);
          3'd4: m_lo <= longint'(wdata_i);
          3'd5: begin m_ofs_ns <= longint'(wdata_i); m_ofs_sec <= (m_hi << 32) | m_lo; end
          3'd6: m_step <= longint'(wdata_i);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i); wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  // read and compare with the model
  task automatic rd_model(input logic [2:0] a, input string req);
    @(negedge clk_i); rd_i = 1'b1; addr_i = a;
    @(negedge clk_i); rd_i = 1'b0;
    chk(rdata_o, exp_rd, req);
  endtask

  task automatic rd_exp(input logic [2:0] a, input logic [31:0] e, input string req);
    @(negedge clk_i); rd_i = 1'b1; addr_i = a;
    @(negedge clk_i); rd_i = 1'b0;
    chk(rdata_o, e, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(32'(irq_o), 32'd0, "R1 irq in reset");
    chk(rdata_o, 32'd0, "R1 rdata in reset");
    rst_ni = 1'b1;
    rd_exp(3'd6, 32'h0080_0000, "R1 step default");
    rd_exp(3'd5, 32'd0, "R1 offset ns");
    rd_exp(3'd4, 32'd0, "R1 offset sec");
    rd_exp(3'd7, 32'd0, "R1 irq flag");
    rd_model(3'd1, "R1 time seconds zero");

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op = VECS[i][36:35];
      logic [2:0]  a  = VECS[i][34:32];
      logic [31:0] d  = VECS[i][31:0];
      case (op)
        OP_RD:   rd_model(a, $sformatf("R2-vec%0d read word %0d", i, a));
        OP_WR:   wr(a, d);
        default: repeat (d) @(negedge clk_i);
      endcase
    end
    rd_model(3'd1, "R3 seconds low after wrap");
    rd_model(3'd2, "R3 seconds high carry");

    // freeze the time base for interrupt tests
    wr(3'd6, 32'd0);
    repeat (3) @(negedge clk_i);
    wr(3'd7, 32'd1);
    chk(32'(irq_o), 32'd0, "R9 clear");
    rd_exp(3'd7, 32'd0, "R9 flag read");
    wr(3'd3, 32'd0);
    wr(3'd4, 32'd0);
    wr(3'd5, 32'd5000);
    repeat (3) @(negedge clk_i);
    chk(32'(irq_o), 32'd0, "R8 offset jump quiet");
    rd_model(3'd0, "R2 frozen time");

    wr(3'd6, 32'h0080_0000);
    repeat (14) @(negedge clk_i);
    chk(32'(irq_o), 32'd1, "R8 tick after crossing");
    wr(3'd7, 32'd0);
    chk(32'(irq_o), 32'd1, "R9 write zero ignored");
    rd_exp(3'd7, 32'd1, "R9 flag read set");

    wr(3'd6, 32'h0640_0000);  // 100 ns per cycle: crossing every edge
    repeat (2) @(negedge clk_i);
    wr(3'd7, 32'd1);
    chk(32'(irq_o), 32'd1, "R9 tick wins over clear");
    wr(3'd6, 32'd0);
    repeat (2) @(negedge clk_i);
    wr(3'd7, 32'd1);
    chk(32'(irq_o), 32'd0, "R9 clear when idle");
    rd_model(3'd0, "R4 time after ticks");
    finish_run();
  end
endmodule